// File: doc/BRIEF.md
# Programmable Panel Raster Timing Generator

This block produces the raster timing for a TFT panel: horizontal sync, vertical sync, data enable, the pixel and line position inside the visible area, and a frame event pulse. Three 32-bit timing words set the geometry. The first word covers the horizontal segments, the second covers the vertical segments, and the third holds the data-enable window and the polarity controls. Every step is qualified by a pixel clock enable, so a separate divider can set the pixel rate.

A mode state machine has three states. OFF is entered whenever `en` is low. DARK is entered when `en` is high and `pwr` is low. LIVE is entered when both are high. Each state can reach the others directly, and each move is taken on the clock edge after the inputs change. The counters run in DARK and in LIVE, but the panel-facing outputs are released only in LIVE. This means software can start the timing, let the panel supply settle, and only then raise power. For shutdown it drops power first and enable second.

Two segment machines run below the mode machine. The horizontal machine walks ACT → FP → SYNC → BP → ACT once per line. The vertical machine walks ACT → FP → SYNC → BP → ACT once per frame. It leaves out FP when that length is zero (ACT → SYNC), and it leaves out BP when that length is zero (SYNC → ACT). A vertical move always happens at the end of a line. The timing words are copied into a shadow at the frame boundary, and they are copied on every cycle while the block is OFF.

Top module: `lcd_raster_gen`

## Requirements
- R1: After reset, and from one clock after `en` is sampled low, `hsync`, `vsync`, `de`, `pclk_fall`, `frm_evt`, `px_x` and `px_y` are all 0.
- R2: One line is made of four segments counted in `pix_ce` ticks, in this order: active 16·(P+1), front porch F+1, sync S+1, back porch B+1. P is `tmg_h[7:2]`, S is `tmg_h[15:8]`, F is `tmg_h[23:16]` and B is `tmg_h[31:24]`. The raw horizontal sync is asserted during the sync segment.
- R3: One frame is made of four segments counted in lines, in this order: active L+1, front porch VF, sync VS+1, back porch VB. L is `tmg_v[9:0]`, VS is `tmg_v[15:10]`, VF is `tmg_v[23:16]` and VB is `tmg_v[31:24]`. A porch of length zero is left out. The raw vertical sync covers whole sync lines.
- R4: Raw data enable is true only when both counters are in their active segments and the pixel index is at most C, where C is `tmg_x[25:16]`. `px_x` counts 0 upward through the active pixels, `px_y` counts 0 upward through the active lines, and each reads 0 outside its active segment.
- R5: While LIVE, `tmg_x` bit 0 inverts `hsync`, bit 1 inverts `vsync` and bit 2 inverts `de`.
- R6: While LIVE, `pclk_fall` is equal to `tmg_x` bit 3, which selects the opposite pixel clock edge for data launch.
- R7: A cycle with `pix_ce` low changes no counter and no segment.
- R8: While `en` is high and `pwr` is low, the counters keep running and `frm_evt` still pulses, but every panel output is 0. Panel outputs become active one clock after `pwr` is sampled high.
- R9: `frm_evt` is a one-clock pulse. It fires on the clock at which the vertical machine enters the segment chosen by `evt_sel`, using the codes 0 active, 1 front porch, 2 sync and 3 back porch. It does not fire at enable.
- R10: A timing word written during a frame takes effect from the next frame start, so the frame in progress finishes with the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_ce | input | 1 | Pixel clock enable |
| tmg_h | input | 32 | Horizontal timing word |
| tmg_v | input | 32 | Vertical timing word |
| tmg_x | input | 32 | Polarity, clock edge and data-enable window word |
| en | input | 1 | Timing enable |
| pwr | input | 1 | Panel power |
| evt_sel | input | 2 | Frame event position select |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pclk_fall | output | 1 | Launch data on the opposite pixel clock edge |
| px_x | output | 11 | Active pixel index |
| px_y | output | 11 | Active line index |
| frm_evt | output | 1 | Frame event pulse |

## Verification
The assertions assume three things about the inputs. First, a timing word only changes while the block is OFF or in a frame that the shadow will replace at its boundary. Second, `pwr` is never expected to produce panel activity without `en`. Third, line lengths are far greater than one clock, so two frame events can never be adjacent. The stimulus changes the words only with `en` low, or right after a frame start event. It holds `pix_ce` high except in the freeze test. It uses lines of at least 19 clocks.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    // field layout of the horizontal word
    localparam int PPL_LSB = 2;
    localparam int PPL_W   = 6;
    localparam int HSW_LSB = 8;
    localparam int HFP_LSB = 16;
    localparam int HBP_LSB = 24;
    localparam int HFLD_W  = 8;

    // field layout of the vertical word
    localparam int LPP_LSB = 0;
    localparam int LPP_W   = 10;
    localparam int VSW_LSB = 10;
    localparam int VSW_W   = 6;
    localparam int VFP_LSB = 16;
    localparam int VBP_LSB = 24;
    localparam int VFLD_W  = 8;

    // field layout of the extra word
    localparam int INV_HS_BIT = 0;
    localparam int INV_VS_BIT = 1;
    localparam int INV_DE_BIT = 2;
    localparam int EDGE_BIT   = 3;
    localparam int CPL_LSB    = 16;
    localparam int CPL_W      = 10;

    // counter widths able to hold the largest segment length
    localparam int HCNT_W = PPL_W + 5;
    localparam int VCNT_W = LPP_W + 1;

    typedef enum logic [1:0] {
        SEG_ACT  = 2'd0,
        SEG_FP   = 2'd1,
        SEG_SYNC = 2'd2,
        SEG_BP   = 2'd3
    } seg_e;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_DARK = 2'd1,
        MODE_LIVE = 2'd2
    } mode_e;

    typedef struct packed {
        logic [HCNT_W-1:0] h_act;
        logic [HCNT_W-1:0] h_fp;
        logic [HCNT_W-1:0] h_sync;
        logic [HCNT_W-1:0] h_bp;
        logic [HCNT_W-1:0] de_win;
        logic [VCNT_W-1:0] v_act;
        logic [VCNT_W-1:0] v_fp;
        logic [VCNT_W-1:0] v_sync;
        logic [VCNT_W-1:0] v_bp;
        logic [2:0]        inv;
        logic              edge_sel;
    } tcfg_t;

    localparam tcfg_t CFG_RST = '{
        h_act:  HCNT_W'(1),
        h_fp:   HCNT_W'(1),
        h_sync: HCNT_W'(1),
        h_bp:   HCNT_W'(1),
        de_win: HCNT_W'(1),
        v_act:  VCNT_W'(1),
        v_fp:   VCNT_W'(0),
        v_sync: VCNT_W'(1),
        v_bp:   VCNT_W'(0),
        inv:    3'b000,
        edge_sel: 1'b0
    };

endpackage

// File: rtl/lcdt_shadow.sv
module lcdt_shadow
    import lcdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] w_h,
    input  logic [31:0] w_v,
    input  logic [31:0] w_x,
    output tcfg_t       cfg
);

    tcfg_t dec;
    logic  unused_bits;

    assign unused_bits = ^{w_h[1:0], w_x[15:4], w_x[31:26]};

    // decode the packed words into segment lengths in ticks / lines
    always_comb begin
        dec.h_act    = (HCNT_W'(w_h[PPL_LSB +: PPL_W]) + HCNT_W'(1)) << 4;
        dec.h_fp     = HCNT_W'(w_h[HFP_LSB +: HFLD_W]) + HCNT_W'(1);
        dec.h_sync   = HCNT_W'(w_h[HSW_LSB +: HFLD_W]) + HCNT_W'(1);
        dec.h_bp     = HCNT_W'(w_h[HBP_LSB +: HFLD_W]) + HCNT_W'(1);
        dec.de_win   = HCNT_W'(w_x[CPL_LSB +: CPL_W]) + HCNT_W'(1);
        dec.v_act    = VCNT_W'(w_v[LPP_LSB +: LPP_W]) + VCNT_W'(1);
        dec.v_fp     = VCNT_W'(w_v[VFP_LSB +: VFLD_W]);
        dec.v_sync   = VCNT_W'(w_v[VSW_LSB +: VSW_W]) + VCNT_W'(1);
        dec.v_bp     = VCNT_W'(w_v[VBP_LSB +: VFLD_W]);
        dec.inv      = {w_x[INV_DE_BIT], w_x[INV_VS_BIT], w_x[INV_HS_BIT]};
        dec.edge_sel = w_x[EDGE_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= CFG_RST;
        end else if (load) begin
            cfg <= dec;
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) |-> $stable(cfg)); // R10

endmodule

// File: rtl/lcdt_hseq.sv
module lcdt_hseq
    import lcdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              run,
    input  logic              ce,
    input  logic [HCNT_W-1:0] len_act,
    input  logic [HCNT_W-1:0] len_fp,
    input  logic [HCNT_W-1:0] len_sync,
    input  logic [HCNT_W-1:0] len_bp,
    output seg_e              h_seg,
    output logic [HCNT_W-1:0] h_cnt,
    output logic              line_end
);

    logic [HCNT_W-1:0] seg_len;
    seg_e              seg_nxt;
    logic              seg_end;

    always_comb begin
        unique case (h_seg)
            SEG_ACT:  begin seg_len = len_act;  seg_nxt = SEG_FP;   end
            SEG_FP:   begin seg_len = len_fp;   seg_nxt = SEG_SYNC; end
            SEG_SYNC: begin seg_len = len_sync; seg_nxt = SEG_BP;   end
            SEG_BP:   begin seg_len = len_bp;   seg_nxt = SEG_ACT;  end
        endcase
    end

    assign seg_end  = (h_cnt == seg_len - HCNT_W'(1));
    assign line_end = run && ce && (h_seg == SEG_BP) && seg_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_seg <= SEG_ACT;
            h_cnt <= '0;
        end else if (clr) begin
            h_seg <= SEG_ACT;
            h_cnt <= '0;
        end else if (run && ce) begin
            if (seg_end) begin
                h_seg <= seg_nxt;
                h_cnt <= '0;
            end else begin
                h_cnt <= h_cnt + HCNT_W'(1);
            end
        end
    end

    AST_HCNT_IN_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        h_cnt < seg_len); // R2

    AST_HOLD_WITHOUT_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !clr) |=> ($stable(h_cnt) && $stable(h_seg))); // R7

endmodule

// File: rtl/lcdt_vseq.sv
module lcdt_vseq
    import lcdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              line_end,
    input  logic [1:0]        sel,
    input  logic [VCNT_W-1:0] len_act,
    input  logic [VCNT_W-1:0] len_fp,
    input  logic [VCNT_W-1:0] len_sync,
    input  logic [VCNT_W-1:0] len_bp,
    output seg_e              v_seg,
    output logic [VCNT_W-1:0] v_cnt,
    output logic              frame_end,
    output logic              evt
);

    logic [VCNT_W-1:0] seg_len;
    seg_e              seg_nxt;
    logic              seg_end;
    logic              step;

    // zero-length porches are skipped
    always_comb begin
        unique case (v_seg)
            SEG_ACT: begin
                seg_len = len_act;
                seg_nxt = (len_fp != '0) ? SEG_FP : SEG_SYNC;
            end
            SEG_FP: begin
                seg_len = len_fp;
                seg_nxt = SEG_SYNC;
            end
            SEG_SYNC: begin
                seg_len = len_sync;
                seg_nxt = (len_bp != '0) ? SEG_BP : SEG_ACT;
            end
            SEG_BP: begin
                seg_len = len_bp;
                seg_nxt = SEG_ACT;
            end
        endcase
    end

    assign seg_end   = (v_cnt == seg_len - VCNT_W'(1));
    assign step      = line_end && seg_end;
    assign frame_end = step && (seg_nxt == SEG_ACT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_seg <= SEG_ACT;
            v_cnt <= '0;
            evt   <= 1'b0;
        end else if (clr) begin
            v_seg <= SEG_ACT;
            v_cnt <= '0;
            evt   <= 1'b0;
        end else begin
            evt <= step && (seg_nxt == seg_e'(sel));
            if (step) begin
                v_seg <= seg_nxt;
                v_cnt <= '0;
            end else if (line_end) begin
                v_cnt <= v_cnt + VCNT_W'(1);
            end
        end
    end

    AST_VCNT_IN_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        v_cnt < seg_len); // R3

    AST_VSEG_ON_LINE_END: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(clr) && (v_seg != $past(v_seg))) |-> $past(line_end)); // R3

    AST_EVT_LONE: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt); // R9

endmodule

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen
    import lcdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_ce,
    input  logic [31:0]       tmg_h,
    input  logic [31:0]       tmg_v,
    input  logic [31:0]       tmg_x,
    input  logic              en,
    input  logic              pwr,
    input  logic [1:0]        evt_sel,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic              pclk_fall,
    output logic [HCNT_W-1:0] px_x,
    output logic [VCNT_W-1:0] px_y,
    output logic              frm_evt
);

    mode_e             mode, mode_nxt;
    tcfg_t             cfg;
    seg_e              h_seg, v_seg;
    logic [HCNT_W-1:0] h_cnt;
    logic [VCNT_W-1:0] v_cnt;
    logic              line_end, frame_end;
    logic              clr, run, load, live;
    logic [2:0]        raw, lvl;

    // mode state machine: next state
    always_comb begin
        mode_nxt = mode;
        unique case (mode)
            MODE_OFF:  if (en) mode_nxt = pwr ? MODE_LIVE : MODE_DARK;
            MODE_DARK: if (!en) mode_nxt = MODE_OFF;
                       else if (pwr) mode_nxt = MODE_LIVE;
            MODE_LIVE: if (!en) mode_nxt = MODE_OFF;
                       else if (!pwr) mode_nxt = MODE_DARK;
            default:   mode_nxt = MODE_OFF;
        endcase
    end

    // mode state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode <= MODE_OFF;
        else        mode <= mode_nxt;
    end

    assign clr  = !en;
    assign run  = (mode != MODE_OFF);
    assign load = (mode == MODE_OFF) || frame_end;

    lcdt_shadow u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .w_h   (tmg_h),
        .w_v   (tmg_v),
        .w_x   (tmg_x),
        .cfg   (cfg)
    );

    lcdt_hseq u_hseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .run      (run),
        .ce       (pix_ce),
        .len_act  (cfg.h_act),
        .len_fp   (cfg.h_fp),
        .len_sync (cfg.h_sync),
        .len_bp   (cfg.h_bp),
        .h_seg    (h_seg),
        .h_cnt    (h_cnt),
        .line_end (line_end)
    );

    lcdt_vseq u_vseq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .line_end  (line_end),
        .sel       (evt_sel),
        .len_act   (cfg.v_act),
        .len_fp    (cfg.v_fp),
        .len_sync  (cfg.v_sync),
        .len_bp    (cfg.v_bp),
        .v_seg     (v_seg),
        .v_cnt     (v_cnt),
        .frame_end (frame_end),
        .evt       (frm_evt)
    );

    // output process
    always_comb begin
        live      = (mode == MODE_LIVE);
        raw[0]    = (h_seg == SEG_SYNC);
        raw[1]    = (v_seg == SEG_SYNC);
        raw[2]    = (h_seg == SEG_ACT) && (v_seg == SEG_ACT) && (h_cnt < cfg.de_win);
        px_x      = (live && h_seg == SEG_ACT) ? h_cnt : '0;
        px_y      = (live && v_seg == SEG_ACT) ? v_cnt : '0;
        pclk_fall = live && cfg.edge_sel;
    end

    for (genvar g = 0; g < 3; g++) begin : g_pol
        assign lvl[g] = live && (raw[g] ^ cfg.inv[g]);
    end

    assign hsync = lvl[0];
    assign vsync = lvl[1];
    assign de    = lvl[2];

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!hsync && !vsync && !de && !pclk_fall && !frm_evt
                 && px_x == '0 && px_y == '0)); // R1

    AST_DE_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> $past(pwr)); // R8

endmodule

// File: tb/lcd_raster_gen_bench.sv
module lcd_raster_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_ce = 1'b1;
    logic [31:0] tmg_h = '0, tmg_v = '0, tmg_x = '0;
    logic        en = 1'b0, pwr = 1'b0;
    logic [1:0]  evt_sel = 2'd0;
    logic        hsync, vsync, de, pclk_fall, frm_evt;
    logic [10:0] px_x, px_y;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    lcd_raster_gen u_lcd_raster_gen (
        .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce),
        .tmg_h(tmg_h), .tmg_v(tmg_v), .tmg_x(tmg_x),
        .en(en), .pwr(pwr), .evt_sel(evt_sel),
        .hsync(hsync), .vsync(vsync), .de(de), .pclk_fall(pclk_fall),
        .px_x(px_x), .px_y(px_y), .frm_evt(frm_evt)
    );

    // P F S B, L VF VS VB, C, inversion bits
    localparam int VEC [4][10] = '{
        '{0, 1, 1, 1,  1, 1, 0, 1,  15, 0},
        '{1, 0, 2, 0,  2, 0, 1, 0,  20, 7},
        '{0, 3, 0, 2,  3, 2, 2, 3,  15, 2},
        '{0, 0, 0, 0,  0, 0, 0, 0,  40, 1}
    };

    function automatic logic [31:0] mk_h(int p, int f, int s, int b);
        return (32'(b) << 24) | (32'(f) << 16) | (32'(s) << 8) | (32'(p) << 2);
    endfunction

    function automatic logic [31:0] mk_v(int l, int vf, int vs, int vb);
        return (32'(vb) << 24) | (32'(vf) << 16) | (32'(vs) << 10) | 32'(l);
    endfunction

    function automatic logic [31:0] mk_x(int c, int inv);
        return (32'(c) << 16) | 32'(inv);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic stop_blk();
        en = 1'b0;
        @(negedge clk);
    endtask

    task automatic start_blk(input logic [31:0] wh, wv, wx, input logic [1:0] s, input bit pw);
        @(negedge clk);
        tmg_h = wh; tmg_v = wv; tmg_x = wx; evt_sel = s; pwr = pw;
        en = 1'b1;
    endtask

    task automatic measure(input bit wait_evt, input bit ih, iv, id,
                           output int n, output int dec, output int hsc, output int vsc);
        if (wait_evt) begin
            do @(negedge clk); while (!frm_evt);
        end
        n = 0; dec = 0; hsc = 0; vsc = 0;
        do begin
            dec += int'(de ^ id);
            hsc += int'(hsync ^ ih);
            vsc += int'(vsync ^ iv);
            n++;
            @(negedge clk);
        end while (!frm_evt);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n, dc, hc, vc;
        logic [31:0] v1h, v1v, v1x;
        v1h = mk_h(0, 1, 1, 1);
        v1v = mk_v(1, 1, 0, 1);
        v1x = mk_x(15, 0);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check({hsync, vsync, de, pclk_fall, frm_evt} == 5'b0 && px_x == 0 && px_y == 0,
              "R1 reset", int'({hsync, vsync, de, pclk_fall, frm_evt}), 0);

        // table walk: frame geometry, sync widths, data enable and polarity
        for (int i = 0; i < 4; i++) begin
            int line, lines, dew;
            bit ih, iv, id;
            ih = VEC[i][9][0]; iv = VEC[i][9][1]; id = VEC[i][9][2];
            line  = 16 * (VEC[i][0] + 1) + VEC[i][1] + VEC[i][2] + VEC[i][3] + 3;
            lines = VEC[i][4] + 1 + VEC[i][5] + VEC[i][6] + 1 + VEC[i][7];
            dew   = (VEC[i][8] + 1 < 16 * (VEC[i][0] + 1)) ? VEC[i][8] + 1 : 16 * (VEC[i][0] + 1);
            stop_blk();
            start_blk(mk_h(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]),
                      mk_v(VEC[i][4], VEC[i][5], VEC[i][6], VEC[i][7]),
                      mk_x(VEC[i][8], VEC[i][9]), 2'd0, 1'b1);
            measure(1'b1, ih, iv, id, n, dc, hc, vc);
            check(n == line * lines, "R2 R3 frame period", n, line * lines);
            check(hc == (VEC[i][2] + 1) * lines, "R2 R5 hsync ticks", hc, (VEC[i][2] + 1) * lines);
            check(vc == (VEC[i][6] + 1) * line, "R3 R5 vsync ticks", vc, (VEC[i][6] + 1) * line);
            check(dc == dew * (VEC[i][4] + 1), "R4 R5 de ticks", dc, dew * (VEC[i][4] + 1));
        end

        // R1 disable while running
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check({hsync, vsync, de, pclk_fall, frm_evt} == 5'b0 && px_x == 0 && px_y == 0,
              "R1 disable", int'({hsync, vsync, de, pclk_fall, frm_evt}), 0);

        // R7 freeze with pix_ce low, R4 pixel index
        pix_ce = 1'b0;
        start_blk(v1h, v1v, v1x, 2'd0, 1'b1);
        repeat (20) @(negedge clk);
        check(de == 1'b1 && px_x == 0, "R7 frozen at origin", int'(px_x), 0);
        pix_ce = 1'b1;
        repeat (5) @(negedge clk);
        pix_ce = 1'b0;
        check(px_x == 5, "R4 pixel index", int'(px_x), 5);
        repeat (10) @(negedge clk);
        check(px_x == 5, "R7 hold without ce", int'(px_x), 5);
        pix_ce = 1'b1;

        // R9 event position for each select code
        for (int s = 0; s < 4; s++) begin
            bit pv_vs, ok;
            stop_blk();
            start_blk(v1h, v1v, v1x, 2'(s), 1'b1);
            pv_vs = 1'b0;
            do begin
                pv_vs = vsync;
                @(negedge clk);
            end while (!frm_evt);
            case (s)
                0: ok = de && px_x == 0 && px_y == 0;
                1: ok = !de && !vsync && !hsync;
                2: ok = vsync && !pv_vs;
                default: ok = !vsync && pv_vs;
            endcase
            check(ok, "R9 event position", int'({pv_vs, vsync, de}), s);
        end

        // R8 dark mode: counters run, panel outputs stay low
        begin
            int bad, evts, dcount;
            stop_blk();
            start_blk(v1h, v1v, v1x, 2'd0, 1'b0);
            bad = 0; evts = 0;
            for (int k = 0; k < 300; k++) begin
                @(negedge clk);
                if (hsync || vsync || de || px_x != 0 || px_y != 0) bad++;
                if (frm_evt) evts++;
            end
            check(bad == 0, "R8 dark outputs", bad, 0);
            check(evts == 2, "R8 dark events", evts, 2);
            pwr = 1'b1;
            @(negedge clk);
            dcount = 0;
            for (int k = 0; k < 110; k++) begin
                dcount += int'(de);
                @(negedge clk);
            end
            check(dcount == 32, "R8 power up", dcount, 32);
        end

        // R6 clock edge select
        stop_blk();
        start_blk(v1h, v1v, v1x | 32'h8, 2'd0, 1'b1);
        @(negedge clk);
        check(pclk_fall == 1'b1, "R6 edge live", int'(pclk_fall), 1);
        pwr = 1'b0;
        @(negedge clk);
        check(pclk_fall == 1'b0, "R6 edge dark", int'(pclk_fall), 0);

        // R10 mid-frame rewrite applies from the next frame
        stop_blk();
        start_blk(v1h, v1v, v1x, 2'd0, 1'b1);
        do @(negedge clk); while (!frm_evt);
        tmg_h = mk_h(0, 0, 0, 0);
        measure(1'b0, 1'b0, 1'b0, 1'b0, n, dc, hc, vc);
        check(n == 110, "R10 old frame kept", n, 110);
        measure(1'b0, 1'b0, 1'b0, 1'b0, n, dc, hc, vc);
        check(n == 95, "R10 new frame", n, 95);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule